// File: doc/BRIEF.md
# Dual Timer/Counter with Split Mode

This block holds two 16-bit timer/counters, each built from a high byte and a low byte. A per-timer mode selects how the bytes count: a 13-bit count with a small prescaler in the low byte, a plain 16-bit count, or an 8-bit low byte that reloads from the high byte. Each timer counts either machine-cycle ticks or falling edges on its own count pin. Counting starts only when the timer's run bit is set. When gating is enabled, the timer's gate pin must also be high.

Timer 0 has a fourth, split mode. In this mode its low byte is an 8-bit counter that keeps all of timer 0's own controls. Its high byte becomes a separate 8-bit timer that always counts machine cycles. That high byte is started by timer 1's run bit and reports its rollover through timer 1's overflow flag. While the split is active, timer 1 gives up every front-end control and counts each machine-cycle tick in its own mode. Its rollovers then raise no flag. Software reaches all state through a small byte-wide register window.

Top module: `dual_timer_split`

## Requirements
- R1: After reset, every register (addresses 0 to 5) reads 0.
- R2: Register window, by address. 0 is control: bit 0 run0, bit 1 ovf0, bit 2 run1, bit 3 ovf1, other bits read 0. 1 is config: timer 0 uses bits [3:0] and timer 1 uses bits [7:4]. Inside each nibble, bits [1:0] are the mode, bit 2 selects pin counting and bit 3 enables gating. 2 and 3 are timer 0 low and high bytes; 4 and 5 are timer 1 low and high bytes. 6 and 7 read 0. A written value reads back.
- R3: Mode 0 counts in the low PRESC_W bits of the low byte and carries into the high byte. The upper low-byte bits are kept. When the high byte rolls over from FF, the overflow flag is set.
- R4: Mode 1 counts the 16-bit pair. A step from FFFF gives 0000 and sets the overflow flag.
- R5: Mode 2 counts the low byte. A step from FF loads the low byte from the high byte and sets the flag. The high byte is unchanged.
- R6: Outside the split case, a timer advances once per machine-cycle tick only while its run bit is 1 and either gating is off or its gate pin is high.
- R7: With pin counting selected, a timer advances once for each falling edge of its count pin. The pin is sampled only on machine-cycle ticks.
- R8: In split mode (timer 0 mode 3), timer 0's low byte is an 8-bit counter under timer 0's controls. Its rollover sets ovf0 and leaves the high byte alone.
- R9: In split mode, timer 0's high byte counts machine-cycle ticks only while run1 is 1, whatever timer 0's pin-count select is. Its rollover from FF sets ovf1.
- R10: In split mode, timer 1 counts every machine-cycle tick in its own mode (0, 1 or 2). Its run bit, gate enable, gate pin and pin-count select have no effect, and its rollover sets no flag.
- R11: With timer 1 in mode 3, timer 1 holds its count.
- R12: Writing 0 to a flag clears it, but a hardware set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_tick | input | 1 | One-cycle machine-cycle enable (oscillator / 12) |
| cnt_pin0 | input | 1 | External count pin, timer 0 |
| cnt_pin1 | input | 1 | External count pin, timer 1 |
| gate_pin0 | input | 1 | External gate pin, timer 0 |
| gate_pin1 | input | 1 | External gate pin, timer 1 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Combinational read data |

## Verification
The bench builds the block with the default PRESC_W of 5, so mode 0 is the 13-bit count. Both count bytes can be preloaded, which places every carry, reload and rollover boundary within a few ticks. The bench therefore never needs thousands of cycles to reach a wrap. With the default prescaler width, a carry that leaves the upper three low-byte bits untouched can also be seen at the ports.

// File: rtl/dual_timer_split.sv
module dual_timer_split #(
  parameter int PRESC_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mc_tick,
  input  logic       cnt_pin0,
  input  logic       cnt_pin1,
  input  logic       gate_pin0,
  input  logic       gate_pin1,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data
);
  localparam logic [2:0] A_CTL = 3'd0, A_CFG = 3'd1, A_TL0 = 3'd2,
                         A_TH0 = 3'd3, A_TL1 = 3'd4, A_TH1 = 3'd5;

  logic       run0, run1, ovf0, ovf1, pin0_q, pin1_q;
  logic [7:0] cfg, tl0, th0, tl1, th1;

  wire [1:0] m0   = cfg[1:0];
  wire       ext0 = cfg[2];
  wire       gt0  = cfg[3];
  wire [1:0] m1   = cfg[5:4];
  wire       ext1 = cfg[6];
  wire       gt1  = cfg[7];
  wire       split = (m0 == 2'd3);

  wire fall0 = mc_tick & pin0_q & ~cnt_pin0;
  wire fall1 = mc_tick & pin1_q & ~cnt_pin1;

  wire inc0  = run0 & (~gt0 | gate_pin0) & (ext0 ? fall0 : mc_tick);
  wire inc0h = split & run1 & mc_tick;
  wire en1   = split | (run1 & (~gt1 | gate_pin1));
  wire src1  = split ? mc_tick : (ext1 ? fall1 : mc_tick);
  wire inc1  = (m1 != 2'd3) & en1 & src1;

  function automatic logic [16:0] step(input logic [1:0] m, input logic [7:0] h, input logic [7:0] l);
    logic [16:0] r;
    r = {1'b0, h, l};
    case (m)
      2'd0: begin
        if (&l[PRESC_W-1:0]) begin
          r[PRESC_W-1:0] = '0;
          r[15:8] = h + 8'd1;
          r[16] = &h;
        end else begin
          r[PRESC_W-1:0] = l[PRESC_W-1:0] + 1'b1;
        end
      end
      2'd1: r = {1'b0, h, l} + 17'd1;
      2'd2: begin
        if (&l) begin
          r[7:0] = h;
          r[16] = 1'b1;
        end else begin
          r[7:0] = l + 8'd1;
        end
      end
      default: begin
        r[7:0] = l + 8'd1;
        r[16] = &l;
      end
    endcase
    return r;
  endfunction

  wire [16:0] nxt0 = step(m0, th0, tl0);
  wire [16:0] nxt1 = step(m1, th1, tl1);
  wire        set1 = split ? (inc0h & (&th0)) : (inc1 & nxt1[16]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run0 <= 1'b0; run1 <= 1'b0; ovf0 <= 1'b0; ovf1 <= 1'b0;
      pin0_q <= 1'b0; pin1_q <= 1'b0;
      cfg <= '0; tl0 <= '0; th0 <= '0; tl1 <= '0; th1 <= '0;
    end else begin
      if (mc_tick) begin
        pin0_q <= cnt_pin0;
        pin1_q <= cnt_pin1;
      end
      if (inc0) begin
        tl0 <= nxt0[7:0];
        if (!split) th0 <= nxt0[15:8];
      end
      if (inc0h) th0 <= th0 + 8'd1;
      if (inc1) begin
        tl1 <= nxt1[7:0];
        th1 <= nxt1[15:8];
      end
      if (wr_en) begin
        case (wr_addr)
          A_CTL: begin
            run0 <= wr_data[0]; ovf0 <= wr_data[1];
            run1 <= wr_data[2]; ovf1 <= wr_data[3];
          end
          A_CFG: cfg <= wr_data;
          A_TL0: tl0 <= wr_data;
          A_TH0: th0 <= wr_data;
          A_TL1: tl1 <= wr_data;
          A_TH1: th1 <= wr_data;
          default: ;
        endcase
      end
      if (inc0 && nxt0[16]) ovf0 <= 1'b1;
      if (set1) ovf1 <= 1'b1;
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTL:   rd_data = {4'b0, ovf1, run1, ovf0, run0};
      A_CFG:   rd_data = cfg;
      A_TL0:   rd_data = tl0;
      A_TH0:   rd_data = th0;
      A_TL1:   rd_data = tl1;
      A_TH1:   rd_data = th1;
      default: rd_data = '0;
    endcase
  end

  wire wr_t1 = wr_en && (wr_addr == A_TL1 || wr_addr == A_TH1);

  assert_t0_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(run0 && (!gt0 || gate_pin0)) && !(wr_en && wr_addr == A_TL0)) |=> $stable(tl0));

  assert_th0_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (split && !run1 && !(wr_en && wr_addr == A_TH0)) |=> $stable(th0));

  assert_t1_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (split && !m1[1] && mc_tick && !wr_t1) |=> (tl1 != $past(tl1)));

  assert_t1_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (m1 == 2'd3 && !wr_t1) |=> $stable({th1, tl1}));

  assert_m1_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_tick && run0 && !gt0 && !ext0 && m0 == 2'd1 && (&{th0, tl0}) &&
     !(wr_en && (wr_addr == A_TL0 || wr_addr == A_TH0)))
    |=> (ovf0 && th0 == 8'd0 && tl0 == 8'd0));
endmodule

// File: tb/dual_timer_split_tb.sv
module dual_timer_split_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, mc_tick = 0;
  logic cnt_pin0 = 1, cnt_pin1 = 1, gate_pin0 = 0, gate_pin1 = 0;
  logic wr_en = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_timer_split u_dut (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick),
    .cnt_pin0(cnt_pin0), .cnt_pin1(cnt_pin1),
    .gate_pin0(gate_pin0), .gate_pin1(gate_pin1),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // cfg, th0, tl0, ticks, expected th0, expected tl0, expected ovf0
  localparam logic [55:0] VEC [9] = '{
    56'h01_FF_FE_02_00_00_01,
    56'h01_12_FF_01_13_00_00,
    56'h00_FF_1E_02_00_00_01,
    56'h00_05_E0_21_06_E1_00,
    56'h02_80_FE_03_80_81_01,
    56'h02_F0_10_05_F0_15_00,
    56'h03_40_FF_02_40_01_01,
    56'h09_00_00_05_00_00_00,
    56'h01_00_00_0A_00_0A_00
  };

  function automatic string tag_of(input logic [7:0] c);
    if (c[3]) return "R6";
    case (c[1:0])
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a; #1 d = rd_data;
  endtask

  task automatic tick(input int n);
    @(negedge clk); mc_tick = 1;
    repeat (n) @(negedge clk);
    mc_tick = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [55:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], r); chk("R1", r, 8'h00);
    end

    wr(1, 8'hA5); rd(1, r); chk("R2", r, 8'hA5);
    wr(0, 8'h0F); rd(0, r); chk("R2", r, 8'h0F);
    wr(5, 8'h5A); rd(5, r); chk("R2", r, 8'h5A);
    rd(6, r); chk("R2", r, 8'h00);
    wr(0, 8'h00);

    for (int i = 0; i < 9; i++) begin
      v = VEC[i];
      wr(0, 8'h00);
      wr(1, v[55:48]); wr(3, v[47:40]); wr(2, v[39:32]);
      wr(0, 8'h01);
      tick(int'(v[31:24]));
      rd(3, r); chk(tag_of(v[55:48]), r, v[23:16]);
      rd(2, r); chk(tag_of(v[55:48]), r, v[15:8]);
      rd(0, r); chk(tag_of(v[55:48]), {7'b0, r[1]}, v[7:0]);
    end

    // R6: gated, counts with pin high, holds with pin low
    wr(0, 8'h00); wr(1, 8'h09); wr(2, 8'h00); wr(3, 8'h00);
    gate_pin0 = 1; wr(0, 8'h01); tick(4);
    rd(2, r); chk("R6", r, 8'h04);
    gate_pin0 = 0; tick(3);
    rd(2, r); chk("R6", r, 8'h04);

    // R7: pin counting on sampled falling edges
    wr(0, 8'h00); wr(1, 8'h05); wr(2, 8'h00); wr(3, 8'h00); wr(0, 8'h01);
    @(negedge clk); mc_tick = 1;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      cnt_pin0 = 0; repeat (2) @(negedge clk);
      cnt_pin0 = 1; repeat (2) @(negedge clk);
    end
    mc_tick = 0;
    cnt_pin0 = 0; @(negedge clk); cnt_pin0 = 1; @(negedge clk);
    rd(2, r); chk("R7", r, 8'h03);

    // R9 / R10: split mode
    wr(0, 8'h00); wr(1, 8'hE7);
    wr(3, 8'hFE); wr(2, 8'h00); wr(4, 8'hFD); wr(5, 8'h20);
    wr(0, 8'h04); tick(4);
    rd(3, r); chk("R9", r, 8'h02);
    rd(0, r); chk("R9", {7'b0, r[3]}, 8'h01);
    rd(0, r); chk("R8", {7'b0, r[1]}, 8'h00);
    rd(2, r); chk("R8", r, 8'h00);
    rd(4, r); chk("R10", r, 8'h21);
    rd(5, r); chk("R10", r, 8'h20);
    wr(0, 8'h00); tick(3);
    rd(3, r); chk("R9", r, 8'h02);
    rd(4, r); chk("R10", r, 8'h24);
    wr(4, 8'hFF); tick(1);
    rd(4, r); chk("R10", r, 8'h20);
    rd(0, r); chk("R10", {7'b0, r[3]}, 8'h00);

    // R11: timer 1 in mode 3 holds
    wr(0, 8'h00); wr(1, 8'h31); wr(4, 8'h10); wr(5, 8'h10);
    wr(0, 8'h04); tick(5);
    rd(4, r); chk("R11", r, 8'h10);
    rd(5, r); chk("R11", r, 8'h10);

    // R12: hardware set beats software clear in the same cycle
    wr(0, 8'h00); wr(1, 8'h01); wr(3, 8'hFF); wr(2, 8'hFF); wr(0, 8'h01);
    @(negedge clk); wr_en = 1; wr_addr = 0; wr_data = 8'h01; mc_tick = 1;
    @(negedge clk); wr_en = 0; mc_tick = 0;
    rd(0, r); chk("R12", {7'b0, r[1]}, 8'h01);
    rd(2, r); chk("R12", r, 8'h00);
    wr(0, 8'h00);
    rd(0, r); chk("R12", {7'b0, r[1]}, 8'h00);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule